// File: doc/BRIEF.md
# Control Transfer History Buffer

This block keeps a short history of retired control transfers for profiling software. Each transfer comes in as a source address, a target address, a 4-bit type code and a taken flag. A per-type filter drops transfers that software does not want. A surviving transfer becomes one record holding source, target, type and a valid bit. The record is written into a circular array of entries at a write pointer.

In the default mode the array is a ring: each new record lands at the pointer, and once the ring is full it overwrites the oldest record. In stack-emulation mode the array acts as a call stack instead. A call pushes a record, a return removes the newest record, and a co-routine swap replaces the newest record. All other types leave the array alone. In either mode an update touches only one entry.

Software reads entries through a combinational port indexed by age, where index 0 is the newest slot. A synchronous clear input empties the buffer.

Top module: `xfer_hist_buf`

## Requirements
- R1: After reset, or after a clock edge with `clr` high, every entry reads back with `rd_valid` = 0 at every index.
- R2: In ring mode (`stack_en` = 0), a qualifying transfer is stored as the newest record. It reads at index 0 with its source, target, type and `rd_valid` = 1, and each earlier record moves one index older.
- R3: The pointer wraps modulo DEPTH. After more than DEPTH qualifying transfers in ring mode, index DEPTH-1 holds the DEPTH-th most recent record and older records are lost.
- R4: Type codes 0, 6 and 7 are never recorded, whatever the control bits hold.
- R5: For codes 1, 2, 3, 5 and 8 to 15, `type_ctl[code]` = 1 suppresses the transfer. `type_ctl[code]` maps to bit 32+code of the control word.
- R6: Code 4, the not-taken conditional branch, is recorded only when `type_ctl[4]` (control bit 36) is 1.
- R7: An input of code 4 or 5 is a conditional branch. Its effective code is 5 when `in_taken` = 1 and 4 otherwise. That effective code is the one filtered and stored.
- R8: In stack mode (`stack_en` = 1), codes 8 and 9 (calls) push a record exactly as in ring mode.
- R9: In stack mode, code 13 (return) removes the newest record and stores nothing. If the newest slot is empty, the buffer is unchanged.
- R10: In stack mode, code 12 (co-routine swap) overwrites the newest record in place when that slot is valid. Otherwise it pushes.
- R11: In stack mode, every code other than 8, 9, 12 and 13 leaves the buffer unchanged.
- R12: `clr` takes priority over a transfer presented in the same cycle, and that transfer is dropped.
- R13: With `in_valid` = 0 the buffer is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous buffer clear |
| in_valid | input | 1 | A retired transfer is presented this cycle |
| in_src | input | AW | Transfer source address |
| in_dst | input | AW | Transfer target address |
| in_type | input | 4 | Transfer type code |
| in_taken | input | 1 | Taken flag for conditional branches |
| stack_en | input | 1 | Stack-emulation mode select |
| type_ctl | input | 16 | Per-code inhibit bits (bit 4 is an enable) |
| rd_idx | input | PTR_W | Read index by age, 0 = newest |
| rd_valid | output | 1 | Valid bit of the addressed entry |
| rd_src | output | AW | Source of the addressed entry |
| rd_dst | output | AW | Target of the addressed entry |
| rd_type | output | 4 | Stored type code of the addressed entry |

## Verification
The assertions assume that DEPTH is a power of two. They also assume that `stack_en` and `type_ctl` are steady at the clock edges of one transfer, and that no input is X once reset is released. The stimulus changes every input only at falling edges, with all values drawn from defined ranges. It changes mode and filter settings only between transfers. In the stack phase the random mix is biased toward calls, returns and swaps, so that both pops of an empty slot and pointer wrap on pushes happen regularly.

// File: rtl/xhb_pkg.sv
// Package: shared action encoding, type code constants and helper functions
// for the control transfer history buffer. Assumes 4-bit type codes.
package xhb_pkg;

    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_APPEND  = 2'd1,
        ACT_POP     = 2'd2,
        ACT_REPLACE = 2'd3
    } xhb_act_e;

    localparam int TYPE_W = 4;

    localparam logic [TYPE_W-1:0] TC_NONE      = 4'd0;
    localparam logic [TYPE_W-1:0] TC_BR_NT     = 4'd4;
    localparam logic [TYPE_W-1:0] TC_BR_TK     = 4'd5;
    localparam logic [TYPE_W-1:0] TC_RSVD_LO   = 4'd6;
    localparam logic [TYPE_W-1:0] TC_RSVD_HI   = 4'd7;
    localparam logic [TYPE_W-1:0] TC_CALL_IND  = 4'd8;
    localparam logic [TYPE_W-1:0] TC_CALL_DIR  = 4'd9;
    localparam logic [TYPE_W-1:0] TC_SWAP      = 4'd12;
    localparam logic [TYPE_W-1:0] TC_RETURN    = 4'd13;

    // Fold a conditional branch code onto its taken or not-taken form.
    function automatic logic [TYPE_W-1:0] fold_branch(input logic [TYPE_W-1:0] code,
                                                      input logic taken);
        if (code == TC_BR_NT || code == TC_BR_TK)
            return taken ? TC_BR_TK : TC_BR_NT;
        return code;
    endfunction

    // Codes that may never enter the buffer.
    function automatic logic never_kept(input logic [TYPE_W-1:0] code);
        return (code == TC_NONE) || (code == TC_RSVD_LO) || (code == TC_RSVD_HI);
    endfunction

    function automatic logic is_call(input logic [TYPE_W-1:0] code);
        return (code == TC_CALL_IND) || (code == TC_CALL_DIR);
    endfunction

endpackage

// File: rtl/xhb_filter.sv
// Filter and action decode. Folds conditional branches by the taken flag,
// applies the per-code inhibit/enable bits, then picks the buffer action
// for the current mode. Purely combinational; clk and rst_n serve only
// the assertions. Assumes top_valid reflects the entry below the pointer.
module xhb_filter
    import xhb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [TYPE_W-1:0] in_type,
    input  logic              in_taken,
    input  logic              stack_en,
    input  logic [15:0]       type_ctl,
    input  logic              top_valid,
    output logic [TYPE_W-1:0] rec_type,
    output xhb_act_e          act
);

    logic ctl_bit;
    logic passes;

    // Effective code and the control bit that governs it.
    always_comb begin
        rec_type = fold_branch(in_type, in_taken);
        ctl_bit  = type_ctl[rec_type];
    end

    // Qualification: known code, and enable (code 4) or not inhibited (others).
    always_comb begin
        if (!in_valid || never_kept(rec_type))
            passes = 1'b0;
        else if (rec_type == TC_BR_NT)
            passes = ctl_bit;
        else
            passes = !ctl_bit;
    end

    // Action select for ring or stack mode.
    always_comb begin
        act = ACT_NONE;
        if (passes) begin
            if (!stack_en)
                act = ACT_APPEND;
            else if (is_call(rec_type))
                act = ACT_APPEND;
            else if (rec_type == TC_RETURN)
                act = top_valid ? ACT_POP : ACT_NONE;
            else if (rec_type == TC_SWAP)
                act = top_valid ? ACT_REPLACE : ACT_APPEND;
        end
    end

    // R4: codes 0, 6 and 7 never cause an update.
    p_rsvd_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_type == 4'd0 || in_type == 4'd6 || in_type == 4'd7)) |-> act == ACT_NONE);

    // R11: in stack mode, only calls, returns and swaps act.
    p_stack_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (stack_en && !(in_type == 4'd8 || in_type == 4'd9 || in_type == 4'd12 || in_type == 4'd13))
        |-> act == ACT_NONE);

    // R9: a pop is only issued when the newest slot holds a record.
    p_pop_needs_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_POP |-> top_valid);

    // R13: no transfer, no action.
    p_idle_input_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> act == ACT_NONE);

endmodule

// File: rtl/xhb_ptr.sv
// Write pointer. Counts up on append, down on pop, wraps modulo DEPTH.
// Assumes DEPTH is a power of two so the natural wrap of PTR_W bits applies.
module xhb_ptr
    import xhb_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  xhb_act_e         act,
    output logic [PTR_W-1:0] wptr
);

    // Pointer update; reset and clear return it to slot zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            wptr <= '0;
        else begin
            case (act)
                ACT_APPEND: wptr <= wptr + PTR_W'(1);
                ACT_POP:    wptr <= wptr - PTR_W'(1);
                default:    wptr <= wptr;
            endcase
        end
    end

    // R12: clear wins and homes the pointer.
    p_clr_home_r12: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> wptr == '0);

    // R3: an append moves the pointer one slot with wrap.
    p_append_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && act == ACT_APPEND) |=> wptr == $past(wptr) + PTR_W'(1));

    // R10: an in-place swap keeps the pointer.
    p_replace_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && act == ACT_REPLACE) |=> $stable(wptr));

endmodule

// File: rtl/xhb_store.sv
// Entry storage and age-indexed read port. Writes at most one entry per
// cycle: append writes the slot at the pointer, replace writes the slot
// below it, pop clears the valid bit of the slot below it. Only valid bits
// are reset. Assumes DEPTH is a power of two.
module xhb_store
    import xhb_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 32,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  xhb_act_e          act,
    input  logic [PTR_W-1:0]  wptr,
    input  logic [AW-1:0]     in_src,
    input  logic [AW-1:0]     in_dst,
    input  logic [TYPE_W-1:0] rec_type,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic              top_valid,
    output logic              rd_valid,
    output logic [AW-1:0]     rd_src,
    output logic [AW-1:0]     rd_dst,
    output logic [TYPE_W-1:0] rd_type
);

    logic [DEPTH-1:0]  vld;
    logic [AW-1:0]     src_q [DEPTH];
    logic [AW-1:0]     dst_q [DEPTH];
    logic [TYPE_W-1:0] typ_q [DEPTH];

    logic [PTR_W-1:0] top_idx;
    logic [PTR_W-1:0] wr_idx;
    logic [PTR_W-1:0] rd_phys;
    logic [DEPTH-1:0] we_vec;
    logic [DEPTH-1:0] kill_vec;

    // Slot addressing: newest slot, write slot and age-to-slot mapping.
    always_comb begin
        top_idx = wptr - PTR_W'(1);
        wr_idx  = (act == ACT_APPEND) ? wptr : top_idx;
        rd_phys = wptr - PTR_W'(1) - rd_idx;
    end

    // Per-entry write and invalidate strobes.
    for (genvar i = 0; i < DEPTH; i++) begin : g_strobe
        assign we_vec[i]   = (act == ACT_APPEND || act == ACT_REPLACE) && (wr_idx == PTR_W'(i));
        assign kill_vec[i] = (act == ACT_POP) && (top_idx == PTR_W'(i));
    end

    // Valid bits: cleared by reset or clear, set on write, cleared on pop.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            vld <= '0;
        else
            vld <= (vld | we_vec) & ~kill_vec;
    end

    // Record payload: loaded with the write strobe, no reset needed.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (we_vec[i] && !clr) begin
                src_q[i] <= in_src;
                dst_q[i] <= in_dst;
                typ_q[i] <= rec_type;
            end
        end
    end

    // Read port and the newest-slot flag used by the action decode.
    always_comb begin
        top_valid = vld[top_idx];
        rd_valid  = vld[rd_phys];
        rd_src    = src_q[rd_phys];
        rd_dst    = dst_q[rd_phys];
        rd_type   = typ_q[rd_phys];
    end

    // R1: a clear leaves no valid entry behind.
    p_clr_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> vld == '0);

    // R2: a written slot reads valid on the next cycle.
    p_written_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && (act == ACT_APPEND || act == ACT_REPLACE)) |=> vld[$past(wr_idx)]);

    // R9: a pop invalidates the slot that was newest.
    p_pop_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && act == ACT_POP) |=> !vld[$past(top_idx)]);

    // R2: one update touches one entry at most.
    p_one_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> $countones(vld ^ $past(vld)) <= 1);

endmodule

// File: rtl/xfer_hist_buf.sv
// Control transfer history buffer, top level. Ties together the filter and
// action decode, the write pointer and the entry storage. Assumes DEPTH is a
// power of two and that mode/filter inputs are steady while a transfer is
// presented.
module xfer_hist_buf
    import xhb_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 32,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              in_valid,
    input  logic [AW-1:0]     in_src,
    input  logic [AW-1:0]     in_dst,
    input  logic [TYPE_W-1:0] in_type,
    input  logic              in_taken,
    input  logic              stack_en,
    input  logic [15:0]       type_ctl,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [AW-1:0]     rd_src,
    output logic [AW-1:0]     rd_dst,
    output logic [TYPE_W-1:0] rd_type
);

    xhb_act_e          act;
    logic [TYPE_W-1:0] rec_type;
    logic [PTR_W-1:0]  wptr;
    logic              top_valid;

    xhb_filter u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_type   (in_type),
        .in_taken  (in_taken),
        .stack_en  (stack_en),
        .type_ctl  (type_ctl),
        .top_valid (top_valid),
        .rec_type  (rec_type),
        .act       (act)
    );

    xhb_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .act   (act),
        .wptr  (wptr)
    );

    xhb_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .act       (act),
        .wptr      (wptr),
        .in_src    (in_src),
        .in_dst    (in_dst),
        .rec_type  (rec_type),
        .rd_idx    (rd_idx),
        .top_valid (top_valid),
        .rd_valid  (rd_valid),
        .rd_src    (rd_src),
        .rd_dst    (rd_dst),
        .rd_type   (rd_type)
    );

endmodule

// File: tb/xfer_hist_buf_test.sv
`timescale 1ns/1ps
module xfer_hist_buf_test;

    localparam int DEPTH = 16;
    localparam int AW    = 32;
    localparam int PTR_W = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clr = 1'b0;
    logic              in_valid = 1'b0;
    logic [AW-1:0]     in_src = '0;
    logic [AW-1:0]     in_dst = '0;
    logic [3:0]        in_type = '0;
    logic              in_taken = 1'b0;
    logic              stack_en = 1'b0;
    logic [15:0]       type_ctl = '0;
    logic [PTR_W-1:0]  rd_idx = '0;
    logic              rd_valid;
    logic [AW-1:0]     rd_src;
    logic [AW-1:0]     rd_dst;
    logic [3:0]        rd_type;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // bench model of the buffer
    bit            m_vld [DEPTH];
    logic [AW-1:0] m_src [DEPTH];
    logic [AW-1:0] m_dst [DEPTH];
    logic [3:0]    m_typ [DEPTH];
    int            m_ptr = 0;

    xfer_hist_buf #(.DEPTH(DEPTH), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
        .in_src(in_src), .in_dst(in_dst), .in_type(in_type), .in_taken(in_taken),
        .stack_en(stack_en), .type_ctl(type_ctl), .rd_idx(rd_idx),
        .rd_valid(rd_valid), .rd_src(rd_src), .rd_dst(rd_dst), .rd_type(rd_type)
    );

    always #5 clk = ~clk;

    function automatic logic [3:0] eff_code(input logic [3:0] t, input logic tk);
        if (t == 4'd4 || t == 4'd5) return tk ? 4'd5 : 4'd4;
        return t;
    endfunction

    function automatic bit kept(input logic [3:0] c, input logic [15:0] ctl);
        if (c == 4'd0 || c == 4'd6 || c == 4'd7) return 1'b0;
        if (c == 4'd4) return ctl[4];
        return !ctl[c];
    endfunction

    function automatic int below(input int p);
        return (p + DEPTH - 1) % DEPTH;
    endfunction

    task automatic model_write(input int slot, input logic [AW-1:0] s,
                               input logic [AW-1:0] d, input logic [3:0] c);
        m_vld[slot] = 1'b1;
        m_src[slot] = s;
        m_dst[slot] = d;
        m_typ[slot] = c;
    endtask

    task automatic model_step(input bit v, input logic [3:0] t, input logic tk,
                              input logic [AW-1:0] s, input logic [AW-1:0] d, input bit c);
        logic [3:0] e;
        e = eff_code(t, tk);
        if (c) begin
            for (int i = 0; i < DEPTH; i++) m_vld[i] = 1'b0;
            m_ptr = 0;
        end else if (v && kept(e, type_ctl)) begin
            if (!stack_en || e == 4'd8 || e == 4'd9) begin
                model_write(m_ptr, s, d, e);
                m_ptr = (m_ptr + 1) % DEPTH;
            end else if (e == 4'd13) begin
                if (m_vld[below(m_ptr)]) begin
                    m_vld[below(m_ptr)] = 1'b0;
                    m_ptr = below(m_ptr);
                end
            end else if (e == 4'd12) begin
                if (m_vld[below(m_ptr)]) model_write(below(m_ptr), s, d, e);
                else begin
                    model_write(m_ptr, s, d, e);
                    m_ptr = (m_ptr + 1) % DEPTH;
                end
            end
        end
    endtask

    // compare every age index against the model
    task automatic check_all(input string req);
        for (int i = 0; i < DEPTH; i++) begin
            int  ph;
            bit  ok;
            ph = (m_ptr - 1 - i + 2 * DEPTH) % DEPTH;
            rd_idx = PTR_W'(i);
            #0.2;
            checks++;
            ok = (rd_valid == m_vld[ph]);
            if (ok && m_vld[ph])
                ok = (rd_src == m_src[ph]) && (rd_dst == m_dst[ph]) && (rd_type == m_typ[ph]);
            if (!ok) begin
                errors++;
                $display("FAIL %s idx %0d: got v=%0b s=%h d=%h t=%0d exp v=%0b s=%h d=%h t=%0d",
                         req, i, rd_valid, rd_src, rd_dst, rd_type,
                         m_vld[ph], m_src[ph], m_dst[ph], m_typ[ph]);
            end
        end
    endtask

    task automatic xfer(input bit v, input logic [3:0] t, input logic tk, input bit c);
        logic [AW-1:0] s;
        logic [AW-1:0] d;
        s = $urandom();
        d = $urandom();
        @(negedge clk);
        in_valid = v; in_type = t; in_taken = tk; in_src = s; in_dst = d; clr = c;
        @(posedge clk);
        model_step(v, t, tk, s, d, c);
        @(negedge clk);
        in_valid = 1'b0; clr = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1c0ffee5));
        for (int i = 0; i < DEPTH; i++) m_vld[i] = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");

        // ring mode, all codes allowed except not-taken branch
        stack_en = 1'b0; type_ctl = 16'h0000;
        xfer(1, 4'd9, 0, 0);   check_all("R2 single record");
        xfer(1, 4'd10, 0, 0);  check_all("R2 second record");
        xfer(1, 4'd6, 0, 0);   xfer(1, 4'd7, 1, 0); xfer(1, 4'd0, 0, 0);
        check_all("R4 reserved and none codes");
        xfer(1, 4'd4, 0, 0);   check_all("R6 not-taken off");
        type_ctl = 16'h0010;
        xfer(1, 4'd4, 0, 0);   check_all("R6 not-taken on");
        type_ctl = 16'h0000;
        xfer(1, 4'd4, 1, 0);   check_all("R7 taken folds to 5");
        xfer(1, 4'd5, 0, 0);   check_all("R7 not taken folds to 4");
        type_ctl = 16'h0200;
        xfer(1, 4'd9, 0, 0);   check_all("R5 inhibited call");
        type_ctl = 16'h0000;
        xfer(0, 4'd9, 0, 0);   check_all("R13 idle input");
        for (int k = 0; k < DEPTH + 3; k++) xfer(1, 4'd11, 0, 0);
        check_all("R3 wrap");
        xfer(1, 4'd9, 0, 1);   check_all("R12 clear beats transfer");
        check_all("R1 after clear");

        // stack mode
        stack_en = 1'b1;
        xfer(1, 4'd13, 0, 0);  check_all("R9 pop empty");
        xfer(1, 4'd12, 0, 0);  check_all("R10 swap on empty pushes");
        xfer(1, 4'd8, 0, 0);   xfer(1, 4'd9, 0, 0);
        check_all("R8 calls push");
        xfer(1, 4'd12, 0, 0);  check_all("R10 swap replaces top");
        xfer(1, 4'd5, 1, 0);   xfer(1, 4'd3, 0, 0); xfer(1, 4'd10, 0, 0);
        check_all("R11 others ignored");
        xfer(1, 4'd13, 0, 0);  check_all("R9 return pops");
        for (int k = 0; k < 4; k++) xfer(1, 4'd13, 0, 0);
        check_all("R9 pops past empty");

        // random ring phase
        stack_en = 1'b0;
        for (int k = 0; k < 300; k++) begin
            if (k % 50 == 0) type_ctl = 16'($urandom()) & 16'h3fff;
            xfer($urandom_range(0, 7) != 0, 4'($urandom_range(0, 15)),
                 1'($urandom()), $urandom_range(0, 99) == 0);
            check_all("R2 random ring");
        end

        // random stack phase
        stack_en = 1'b1;
        for (int k = 0; k < 400; k++) begin
            logic [3:0] t;
            int pick;
            if (k % 60 == 0) type_ctl = 16'($urandom()) & 16'hccff;
            pick = $urandom_range(0, 9);
            case (pick)
                0, 1, 2: t = 4'($urandom_range(8, 9));
                3, 4:    t = 4'd13;
                5:       t = 4'd12;
                default: t = 4'($urandom_range(0, 15));
            endcase
            xfer($urandom_range(0, 9) != 0, t, 1'($urandom()), $urandom_range(0, 149) == 0);
            check_all("R8 random stack");
        end

        finish_run();
    end

endmodule